// File: doc/BRIEF.md
# Scaled Saturating Pack Unit

This unit narrows packed fixed-point lanes into saturated lanes of smaller width. A shift amount taken from a field of a 64-bit graphics status word first scales each lane to the left. A fixed arithmetic right shift follows, and then a clamp to the range of the destination lane. A two-bit mode input picks one of three conversions:

- **Mode 0:** four signed halfwords become four unsigned bytes.
- **Mode 1:** two signed words become two unsigned bytes, merged into a shifted copy of the first operand.
- **Mode 2:** two signed words become two signed halfwords.

Each operation is a single-beat request marked by `in_valid`. The result is registered and comes out one clock later with `out_valid`. Between requests the result register keeps its value. The left shift is performed at full width, so no significant bit is lost before the clamp.

Top module: `sat_pack`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high at the rising clock edge. `result` for that request is present in the same cycle.
- R2: While `rst_n` is low, `out_valid` and `result` are zero.
- R3: Mode 2'b00 takes its scale from `status[6:3]`. Signed halfword k of `opb` (bits [16k+15:16k]) is shifted left by the scale and then arithmetically right by 7, i.e. floor(x·2^scale / 128). The clamped byte goes to `result[8k+7:8k]`, and `result[63:32]` is zero.
- R4: In both byte modes, a negative intermediate gives 0 and an intermediate above 255 gives 255.
- R5: Mode 2'b01 starts from `opa` shifted left by 8, with bytes 0 and 4 cleared. So `result[31:8]` = `opa[23:0]` and `result[63:40]` = `opa[55:32]`.
- R6: Mode 2'b01 takes its scale from `status[7:3]`. Signed word w of `opb` gives floor(x·2^scale / 2^23), clamped to 0..255 and written to `result[32w+7:32w]`.
- R7: Mode 2'b10 takes its scale from `status[7:3]`. Signed word w of `opb` gives floor(x·2^scale / 2^16), clamped to -32768..32767. Its 16-bit two's complement goes to `result[16w+15:16w]`, and `result[63:32]` is zero.
- R8: Mode 2'b11 produces an all-zero result.
- R9: The scaled value is formed without loss. A small positive lane that is shifted far left saturates to the maximum and never wraps.
- R10: When `in_valid` is low, `result` keeps its previous value whatever the other inputs do.
- R11: Status bits outside the scale field of the selected mode have no effect on the result. This includes bit 7 in mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Conversion select |
| status | input | 64 | Graphics status word holding the scale field |
| opa | input | 64 | First operand (merge source in mode 2'b01) |
| opb | input | 64 | Packed source lanes |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Packed saturated result |

## Verification
The unit has a single fixed lane geometry, so the bench uses that one build throughout. Because the scale field is at most five bits wide, every scale value of every mode can be swept. Each scale is driven with lane corners and pseudo-random lanes, while the status bits outside the scale field carry random values. This reaches both clamp limits, the exact edges of each clamp range, and the large-shift saturation of small inputs.

// File: rtl/sat_pack.sv
module sat_pack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  mode,
  input  logic [63:0] status,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  output logic        out_valid,
  output logic [63:0] result
);

  localparam int HALF_RSH = 7;
  localparam int BYTE_RSH = 23;
  localparam int FIX_RSH  = 16;

  function automatic logic [7:0] clamp_u8(input logic signed [63:0] v);
    if (v < 0)                   return 8'd0;
    else if (v > 64'sd255)       return 8'd255;
    else                         return v[7:0];
  endfunction

  function automatic logic [15:0] clamp_s16(input logic signed [63:0] v);
    if (v < -64'sd32768)         return 16'h8000;
    else if (v > 64'sd32767)     return 16'h7fff;
    else                         return v[15:0];
  endfunction

  logic [3:0]  sc_half;
  logic [4:0]  sc_word;
  logic [31:0] pk_half;
  logic [15:0] pk_byte;
  logic [31:0] pk_fix;
  logic [63:0] merged;
  logic [63:0] next_result;

  assign sc_half = status[6:3];
  assign sc_word = status[7:3];

  for (genvar k = 0; k < 4; k++) begin : g_half
    logic signed [63:0] ext;
    logic signed [63:0] shl;
    assign ext = {{48{opb[16*k+15]}}, opb[16*k +: 16]};
    assign shl = ext <<< sc_half;
    assign pk_half[8*k +: 8] = clamp_u8(shl >>> HALF_RSH);
  end

  for (genvar w = 0; w < 2; w++) begin : g_word
    logic signed [63:0] ext;
    logic signed [63:0] shl;
    assign ext = {{32{opb[32*w+31]}}, opb[32*w +: 32]};
    assign shl = ext <<< sc_word;
    assign pk_byte[8*w +: 8]   = clamp_u8(shl >>> BYTE_RSH);
    assign pk_fix[16*w +: 16]  = clamp_s16(shl >>> FIX_RSH);
  end

  assign merged = {opa[55:32], pk_byte[15:8], opa[23:0], pk_byte[7:0]};

  always_comb begin
    case (mode)
      2'b00:   next_result = {32'd0, pk_half};
      2'b01:   next_result = merged;
      2'b10:   next_result = {32'd0, pk_fix};
      default: next_result = 64'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= 64'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{status[63:8], status[2:0], opa[63:56], opa[31:24]};

endmodule

module sat_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  mode,
  input logic [63:0] opa,
  input logic        out_valid,
  input logic [63:0] result
);

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && result == 64'd0));

  // R3
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=> result[63:32] == 32'd0);

  // R5
  merge_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01) |=>
      (result[31:8] == $past(opa[23:0]) && result[63:40] == $past(opa[55:32])));

  // R7
  fix_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10) |=> result[63:32] == 32'd0);

  // R8
  idle_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> result == 64'd0);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

endmodule

bind sat_pack sat_pack_chk u_sat_pack_chk (.*);

// File: tb/test_sat_pack.sv
`timescale 1ns/1ps
module test_sat_pack;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] status = 64'd0;
  logic [63:0] opa = 64'd0;
  logic [63:0] opb = 64'd0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9e3779b97f4a7c15;

  always #2 clk = ~clk;

  sat_pack i_sat_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .status(status), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] step(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  function automatic longint fdiv(input longint v, input longint d);
    longint q = v / d;
    if ((v % d) != 0 && v < 0) q = q - 1;
    return q;
  endfunction

  function automatic logic [7:0] sat_u8(input longint v);
    if (v < 0) return 8'd0;
    if (v > 255) return 8'd255;
    return 8'(v);
  endfunction

  function automatic logic [15:0] sat_s16(input longint v);
    if (v < -32768) return 16'h8000;
    if (v > 32767) return 16'h7fff;
    return 16'(v);
  endfunction

  function automatic logic [15:0] corner16(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'hffff;
      3: return 16'h7fff; 4: return 16'h8000; 5: return 16'h00ff;
      6: return 16'h0100; 7: return 16'h0080; default: return 16'h3fc0;
    endcase
  endfunction

  function automatic logic [31:0] corner32(input int i);
    case (i)
      0: return 32'h00000000; 1: return 32'h00000001; 2: return 32'hffffffff;
      3: return 32'h7fffffff; 4: return 32'h80000000; 5: return 32'h007fffff;
      6: return 32'h00800000; 7: return 32'h7fff0000; default: return 32'hffff8000;
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] st,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = 64'd0;
    longint sc16 = longint'(st[6:3]);
    longint sc32 = longint'(st[7:3]);
    case (m)
      2'b00: for (int k = 0; k < 4; k++) begin
        longint x = longint'($signed(b[16*k +: 16]));
        r[8*k +: 8] = sat_u8(fdiv(x * (longint'(1) << sc16), 128));
      end
      2'b01: begin
        r = {a[55:32], 8'd0, a[23:0], 8'd0};
        for (int w = 0; w < 2; w++) begin
          longint x = longint'($signed(b[32*w +: 32]));
          r[32*w +: 8] = sat_u8(fdiv(x * (longint'(1) << sc32), longint'(1) << 23));
        end
      end
      2'b10: for (int w = 0; w < 2; w++) begin
        longint x = longint'($signed(b[32*w +: 32]));
        r[16*w +: 16] = sat_s16(fdiv(x * (longint'(1) << sc32), 65536));
      end
      default: r = 64'd0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] m, input int sc, input int n);
    logic [63:0] st, a, b, exp, held;
    string tag;
    rng = step(rng); st = rng;
    rng = step(rng); a = rng;
    rng = step(rng); b = rng;
    if (m == 2'b00) st[6:3] = sc[3:0];
    else st[7:3] = sc[4:0];
    if (n < 9) begin
      if (m == 2'b00) b = {4{corner16(n)}};
      else b = {corner32(n), corner32((n + 4) % 9)};
    end
    case (m)
      2'b00: tag = "R3/R4/R9/R11";
      2'b01: tag = "R5/R6/R4/R9";
      2'b10: tag = "R7/R9/R11";
      default: tag = "R8";
    endcase
    exp = model(m, st, a, b);
    @(negedge clk);
    mode = m; status = st; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 valid", {63'd0, out_valid}, 64'd1);
    check(tag, result, exp);
    held = result;
    rng = step(rng); opb = rng; opa = ~rng; status = rng ^ 64'h55;
    mode = rng[1:0];
    @(negedge clk);
    check("R1 valid low", {63'd0, out_valid}, 64'd0);
    check("R10 hold", result, held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset valid", {63'd0, out_valid}, 64'd0);
    check("R2 reset result", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after reset", result, 64'd0);
    for (int sc = 0; sc < 16; sc++)
      for (int n = 0; n < 24; n++) run_op(2'b00, sc, n);
    for (int sc = 0; sc < 32; sc++)
      for (int n = 0; n < 24; n++) run_op(2'b01, sc, n);
    for (int sc = 0; sc < 32; sc++)
      for (int n = 0; n < 24; n++) run_op(2'b10, sc, n);
    for (int n = 0; n < 12; n++) run_op(2'b11, n, n);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule